// File: doc/BRIEF.md
# Flash Completion Poller

This block runs on the host side of a parallel NOR flash. After the host has sent a program or erase command sequence to the device, it starts the poller. The poller then finds out when the device's internal operation has ended. It reads one status address again and again over a simple synchronous read port and watches the most significant data bit. While an operation is running, that bit shows the opposite of its final value. For a program, the final value is the MSB of the byte that was written. For an erase, the final value is 1.

Seeing the final value on the status bit is not enough. The lower bits can settle later than the MSB, and the MSB itself can change between two reads near the end of the operation. So the poller never reports the byte that first showed completion. It issues one more read at once and returns that byte, but only if it still shows completion. If it does not, polling goes on.

Reads are spaced by a programmable number of idle cycles, and a programmable limit on poll reads ends a wait that never finishes with a timeout. The poller must only be started after the last write strobe of the command sequence. It must be given an address inside the sector being changed: an address in a protected sector can give a false status.

Top module: `flash_poll_engine`

## Requirements
- R1: A `start` pulse seen while idle latches the operation, address, expected bit, poll limit and gap length. In the next cycle `busy` is high and `rd_req` is high for exactly one cycle with `rd_addr` equal to the latched address. Every later read of the same run uses that same address.
- R2: For a program (`op_erase`=0), a poll response is a completion when `rd_data[7]` equals `prog_msb`.
- R3: For an erase (`op_erase`=1), a poll response is a completion only when `rd_data[7]` is 1, whatever `prog_msb` is.
- R4: After a completing poll response, a confirming read is issued in the very next cycle, with no idle gap. If the confirming byte also shows completion, that whole byte appears on `result_data` together with a one-cycle `done` pulse in the cycle after its response. `busy` is low in that cycle.
- R5: A confirming byte whose bit 7 does not show completion produces no `done`. It is handled like an incomplete poll, and polling resumes.
- R6: After an incomplete response, the next `rd_req` comes exactly `gap_cycles`+1 cycles after the cycle in which the response was presented. With a one-cycle read latency, this gives an issue spacing of `gap_cycles`+2.
- R7: At most `max_polls` poll reads are issued, and a value of 0 counts as 1. Confirming reads are not counted. When the limit is used up without a completion, `timeout` pulses for one cycle in the cycle after the last response, `done` stays low, `busy` falls and `result_data` keeps its previous value.
- R8: `start` is ignored while `busy` is high: the running operation's address, type and result are unaffected.
- R9: During and after reset, `busy`, `done`, `timeout` and `rd_req` are low and `result_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin polling |
| op_erase | input | 1 | 1: erase operation, 0: program operation |
| poll_addr | input | ADDR_W | Address to poll, inside the target sector |
| prog_msb | input | 1 | Bit 7 of the byte programmed (ignored for erase) |
| max_polls | input | CNT_W | Poll read limit, 0 treated as 1 |
| gap_cycles | input | GAP_W | Idle cycles between an incomplete response and the next read |
| rd_req | output | 1 | One-cycle read request |
| rd_addr | output | ADDR_W | Read address |
| rd_valid | input | 1 | Read response strobe |
| rd_data | input | DATA_W | Read response data |
| busy | output | 1 | A polling run is in progress |
| done | output | 1 | One-cycle pulse: completion confirmed |
| timeout | output | 1 | One-cycle pulse: poll limit reached |
| result_data | output | DATA_W | Confirmed byte from the last successful run |

## Verification
The bench builds the poller with its default widths: 20-bit addresses, an 8-bit data bus, a 16-bit poll limit and an 8-bit gap length. It drives the read port from a scripted device model that answers one cycle after each request. Small run-time limits of 0 and 4 polls make the timeout path reachable within a few cycles. Gap values of 0, 1, 2 and 3 make both the gap bypass and the counted gap measurable from the spacing of the requests. The scripts include a confirming read that falls back to busy, a completing byte whose lower bits are still unsettled, and a second start that would complete at once if it were accepted.

// File: rtl/poll_pkg.sv
// Shared types for the flash completion poller.
package poll_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_POLL_REQ,
        ST_POLL_WAIT,
        ST_GAP,
        ST_CONF_REQ,
        ST_CONF_WAIT
    } poll_state_t;
endpackage

// File: rtl/poll_dq7_match.sv
// Decides whether a sampled status bit shows that the embedded operation
// has ended. Assumes the caller passes only the status bit of the byte.
module poll_dq7_match (
    input  logic op_erase,
    input  logic prog_msb,
    input  logic status_bit,
    output logic hit
);
    logic target;

    // Erase ends on a 1; program ends on the true bit written.
    always_comb begin
        target = op_erase ? 1'b1 : prog_msb;
        hit    = (status_bit == target);
    end
endmodule

// File: rtl/poll_attempt_counter.sv
// Counts poll reads of one run against a limit latched at start.
// Assumes incr pulses once per poll read; a limit of 0 is stored as 1.
module poll_attempt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] limit_in,
    input  logic             incr,
    output logic             exhausted
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] limit_q;

    // Latch the limit at start and count poll reads, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            limit_q <= ONE;
        end else if (load) begin
            count_q <= '0;
            limit_q <= (limit_in == '0) ? ONE : limit_in;
        end else if (incr && count_q != TOP) begin
            count_q <= count_q + ONE;
        end
    end

    // The run may not issue another poll once the limit is met.
    always_comb exhausted = (count_q >= limit_q);
endmodule

// File: rtl/poll_gap_timer.sv
// Times the idle gap between an incomplete response and the next poll.
// Assumes tick is high only while the controller sits in its gap state.
module poll_gap_timer #(
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [GAP_W-1:0] len_in,
    input  logic             arm,
    input  logic             tick,
    output logic             gap_zero,
    output logic             gap_last
);
    localparam logic [GAP_W-1:0] ONE = {{(GAP_W-1){1'b0}}, 1'b1};

    logic [GAP_W-1:0] len_q;
    logic [GAP_W-1:0] rem_q;

    // Hold the configured length for the run and count down each gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= '0;
            rem_q <= '0;
        end else begin
            if (load) len_q <= len_in;
            if (arm) begin
                rem_q <= len_q;
            end else if (tick && rem_q != '0) begin
                rem_q <= rem_q - ONE;
            end
        end
    end

    // A zero gap skips the gap state; gap_last marks its final cycle.
    always_comb begin
        gap_zero = (len_q == '0);
        gap_last = (rem_q <= ONE);
    end
endmodule

// File: rtl/flash_poll_engine.sv
// Host-side poller that waits for a flash program or erase to end by
// reading a status address and checking bit 7, then confirms with one
// more read whose full byte is returned. Assumes the command sequence
// has already been written and the address lies in the target sector.
// Assumes each rd_req is answered by exactly one rd_valid later on.
module flash_poll_engine #(
    parameter int ADDR_W     = 20,
    parameter int DATA_W     = 8,
    parameter int STATUS_BIT = 7,
    parameter int CNT_W      = 16,
    parameter int GAP_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op_erase,
    input  logic [ADDR_W-1:0] poll_addr,
    input  logic              prog_msb,
    input  logic [CNT_W-1:0]  max_polls,
    input  logic [GAP_W-1:0]  gap_cycles,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              done,
    output logic              timeout,
    output logic [DATA_W-1:0] result_data
);
    import poll_pkg::*;

    poll_state_t       state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic              erase_q;
    logic              msb_q;
    logic [DATA_W-1:0] result_q;
    logic              done_q;
    logic              timeout_q;

    logic accept;
    logic hit;
    logic exhausted;
    logic gap_zero;
    logic gap_last;
    logic waiting;
    logic resp;
    logic miss;
    logic finish_ok;
    logic give_up;
    logic retry_now;
    logic retry_wait;

    // Classify the current cycle's response and start request.
    always_comb begin
        accept     = start && (state_q == ST_IDLE);
        waiting    = (state_q == ST_POLL_WAIT) || (state_q == ST_CONF_WAIT);
        resp       = rd_valid && waiting;
        miss       = resp && !hit;
        finish_ok  = resp && hit && (state_q == ST_CONF_WAIT);
        give_up    = miss && exhausted;
        retry_now  = miss && !exhausted && gap_zero;
        retry_wait = miss && !exhausted && !gap_zero;
    end

    poll_dq7_match u_match (
        .op_erase  (erase_q),
        .prog_msb  (msb_q),
        .status_bit(rd_data[STATUS_BIT]),
        .hit       (hit)
    );

    poll_attempt_counter #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .limit_in (max_polls),
        .incr     (state_q == ST_POLL_REQ),
        .exhausted(exhausted)
    );

    poll_gap_timer #(.GAP_W(GAP_W)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .len_in  (gap_cycles),
        .arm     (retry_wait),
        .tick    (state_q == ST_GAP),
        .gap_zero(gap_zero),
        .gap_last(gap_last)
    );

    // Next-state selection for the polling sequence.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:      if (accept) state_d = ST_POLL_REQ;
            ST_POLL_REQ:  state_d = ST_POLL_WAIT;
            ST_POLL_WAIT: begin
                if (resp && hit)    state_d = ST_CONF_REQ;
                else if (give_up)   state_d = ST_IDLE;
                else if (retry_now) state_d = ST_POLL_REQ;
                else if (retry_wait) state_d = ST_GAP;
            end
            ST_GAP:       if (gap_last) state_d = ST_POLL_REQ;
            ST_CONF_REQ:  state_d = ST_CONF_WAIT;
            ST_CONF_WAIT: begin
                if (finish_ok)      state_d = ST_IDLE;
                else if (give_up)   state_d = ST_IDLE;
                else if (retry_now) state_d = ST_POLL_REQ;
                else if (retry_wait) state_d = ST_GAP;
            end
            default:      state_d = ST_IDLE;
        endcase
    end

    // State register and per-run latches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            erase_q <= 1'b0;
            msb_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                addr_q  <= poll_addr;
                erase_q <= op_erase;
                msb_q   <= prog_msb;
            end
        end
    end

    // Outcome pulses and the confirmed byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q  <= '0;
            done_q    <= 1'b0;
            timeout_q <= 1'b0;
        end else begin
            done_q    <= finish_ok;
            timeout_q <= give_up;
            if (finish_ok) result_q <= rd_data;
        end
    end

    // Port drive.
    always_comb begin
        rd_req      = (state_q == ST_POLL_REQ) || (state_q == ST_CONF_REQ);
        rd_addr     = addr_q;
        busy        = (state_q != ST_IDLE);
        done        = done_q;
        timeout     = timeout_q;
        result_data = result_q;
    end
endmodule

// File: rtl/flash_poll_engine_chk.sv
// Protocol checker for the flash completion poller, bound to the top.
module flash_poll_engine_chk #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              rd_req,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_valid,
    input logic              busy,
    input logic              done,
    input logic              timeout
);
    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req); // R1
    AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> busy); // R1
    AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && rd_req)); // R1
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(rd_addr)); // R8
    AST_DONE_AFTER_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(rd_valid) && !busy)); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R4
    AST_TIMEOUT_AFTER_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> ($past(rd_valid) && !busy && !done)); // R7
endmodule

bind flash_poll_engine flash_poll_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .rd_req  (rd_req),
    .rd_addr (rd_addr),
    .rd_valid(rd_valid),
    .busy    (busy),
    .done    (done),
    .timeout (timeout)
);

// File: tb/flash_poll_engine_bench.sv
// Directed bench: a scripted device answers each read one cycle later.
module flash_poll_engine_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 20;
    localparam int DATA_W = 8;
    localparam int CNT_W  = 16;
    localparam int GAP_W  = 8;
    localparam int WATCHDOG = 100000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              op_erase = 1'b0;
    logic [ADDR_W-1:0] poll_addr = '0;
    logic              prog_msb = 1'b0;
    logic [CNT_W-1:0]  max_polls = '0;
    logic [GAP_W-1:0]  gap_cycles = '0;
    logic              rd_req;
    logic [ADDR_W-1:0] rd_addr;
    logic              rd_valid = 1'b0;
    logic [DATA_W-1:0] rd_data = '0;
    logic              busy, done, timeout;
    logic [DATA_W-1:0] result_data;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [7:0] script [16];
    int slen = 1;
    int idx = 0;
    int pend = 0;
    int nreq = 0;
    int issue_cyc [64];
    logic [ADDR_W-1:0] issue_addr [64];
    int last_resp = 0;
    int n_done = 0, n_to = 0, end_cyc = 0;
    logic busy_at_end = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_poll_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
                        .GAP_W(GAP_W)) u_flash_poll_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .op_erase(op_erase),
        .poll_addr(poll_addr), .prog_msb(prog_msb), .max_polls(max_polls),
        .gap_cycles(gap_cycles), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy), .done(done),
        .timeout(timeout), .result_data(result_data)
    );

    // Device model and monitor, sampling away from the active edge.
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (pend != 0) begin
            rd_valid = 1'b1;
            rd_data  = script[(idx < slen) ? idx : slen - 1];
            idx = idx + 1;
            pend = 0;
            last_resp = cyc;
        end else begin
            rd_valid = 1'b0;
        end
        if (rd_req) begin
            pend = 1;
            if (nreq < 64) begin
                issue_cyc[nreq]  = cyc;
                issue_addr[nreq] = rd_addr;
            end
            nreq = nreq + 1;
        end
        if (done || timeout) begin
            end_cyc = cyc;
            busy_at_end = busy;
        end
        if (done) n_done = n_done + 1;
        if (timeout) n_to = n_to + 1;
        if (cyc > WATCHDOG) begin
            fails = fails + 1;
            $display("FAIL watchdog: act cycle %0d exp below %0d", cyc, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s: act %0d exp %0d", req, act, exp);
        end
    endtask

    // Launch one run and wait for it to end or for a local limit.
    task automatic launch(input logic er, input logic [ADDR_W-1:0] a,
                          input logic msb, input int maxp, input int gap);
        @(negedge clk);
        idx = 0; pend = 0; nreq = 0; n_done = 0; n_to = 0;
        op_erase = er; poll_addr = a; prog_msb = msb;
        max_polls = CNT_W'(maxp); gap_cycles = GAP_W'(gap);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R1 busy after start", int'(busy), 1);
        chk("R1 rd_req after start", int'(rd_req), 1);
    endtask

    task automatic finish_wait();
        for (int i = 0; i < 2000; i++) begin
            if (n_done + n_to != 0) break;
            @(negedge clk);
        end
        repeat (8) @(negedge clk);
    endtask

    task automatic check_addrs(input string req, input logic [ADDR_W-1:0] a);
        int bad = 0;
        for (int i = 0; i < nreq && i < 64; i++)
            if (issue_addr[i] != a) bad = bad + 1;
        chk(req, bad, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 busy in reset", int'(busy), 0);
        chk("R9 rd_req in reset", int'(rd_req), 0);
        chk("R9 done/timeout in reset", int'(done) + int'(timeout), 0);
        chk("R9 result in reset", int'(result_data), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9 idle after reset", int'(busy) + int'(rd_req), 0);
    endtask

    task automatic t_program_gap3();
        script[0] = 8'h24; script[1] = 8'h24; script[2] = 8'h24;
        script[3] = 8'h93; script[4] = 8'hA5; slen = 5;
        launch(1'b0, 20'h1234A, 1'b1, 16, 3);
        finish_wait();
        chk("R2 program read count", nreq, 5);
        chk("R4 confirmed byte", int'(result_data), 'hA5);
        chk("R4 done count", n_done, 1);
        chk("R4 done one cycle after reply", end_cyc, last_resp + 1);
        chk("R4 busy low at done", int'(busy_at_end), 0);
        chk("R6 gap 3 spacing", issue_cyc[1] - issue_cyc[0], 5);
        chk("R6 gap 3 spacing late", issue_cyc[3] - issue_cyc[2], 5);
        chk("R4 confirm without gap", issue_cyc[4] - issue_cyc[3], 2);
        check_addrs("R1 address held", 20'h1234A);
    endtask

    task automatic t_erase_gap0();
        script[0] = 8'h00; script[1] = 8'h7F; script[2] = 8'hFF;
        script[3] = 8'hFF; slen = 4;
        launch(1'b1, 20'h00010, 1'b0, 16, 0);
        finish_wait();
        chk("R3 erase read count", nreq, 4);
        chk("R3 erase result", int'(result_data), 'hFF);
        chk("R3 erase done", n_done, 1);
        chk("R6 gap 0 spacing", issue_cyc[1] - issue_cyc[0], 2);
    endtask

    task automatic t_program_zero_msb();
        script[0] = 8'hC3; script[1] = 8'hC3; script[2] = 8'h3C;
        script[3] = 8'h3C; slen = 4;
        launch(1'b0, 20'hFFFFF, 1'b0, 16, 1);
        finish_wait();
        chk("R2 msb 0 read count", nreq, 4);
        chk("R2 msb 0 result", int'(result_data), 'h3C);
    endtask

    task automatic t_confirm_flip();
        script[0] = 8'h00; script[1] = 8'h80; script[2] = 8'h00;
        script[3] = 8'h81; script[4] = 8'h80; slen = 5;
        launch(1'b0, 20'h0ABCD, 1'b1, 16, 1);
        finish_wait();
        chk("R5 read count with failed confirm", nreq, 5);
        chk("R5 single done", n_done, 1);
        chk("R5 result from second confirm", int'(result_data), 'h80);
        chk("R5 confirm issued at once", issue_cyc[2] - issue_cyc[1], 2);
        chk("R5 gap after failed confirm", issue_cyc[3] - issue_cyc[2], 3);
    endtask

    task automatic t_timeout();
        script[0] = 8'h00; slen = 1;
        launch(1'b1, 20'h00200, 1'b1, 4, 2);
        finish_wait();
        chk("R7 reads limited to 4", nreq, 4);
        chk("R7 timeout pulse", n_to, 1);
        chk("R7 no done", n_done, 0);
        chk("R7 timeout one cycle after reply", end_cyc, last_resp + 1);
        chk("R7 result kept", int'(result_data), 'h80);
        chk("R7 busy low at timeout", int'(busy_at_end), 0);
    endtask

    task automatic t_limit_zero();
        script[0] = 8'h7F; slen = 1;
        launch(1'b1, 20'h00300, 1'b0, 0, 0);
        finish_wait();
        chk("R7 zero limit gives one read", nreq, 1);
        chk("R7 zero limit timeout", n_to, 1);
    endtask

    task automatic t_start_busy();
        script[0] = 8'h00; script[1] = 8'h00; script[2] = 8'h00;
        script[3] = 8'h00; script[4] = 8'h80; script[5] = 8'h80; slen = 6;
        launch(1'b0, 20'h0A0A0, 1'b1, 16, 2);
        @(negedge clk);
        op_erase = 1'b0; prog_msb = 1'b0; poll_addr = 20'h0B0B0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        finish_wait();
        chk("R8 read count unaffected", nreq, 6);
        chk("R8 single done", n_done, 1);
        chk("R8 result unaffected", int'(result_data), 'h80);
        check_addrs("R8 address unaffected", 20'h0A0A0);
    endtask

    initial begin
        t_reset();
        t_program_gap3();
        t_erase_gap0();
        t_program_zero_msb();
        t_confirm_flip();
        t_timeout();
        t_limit_zero();
        t_start_busy();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule